// File: doc/BRIEF.md
# Interrupt Coalescing Unit

The unit cuts the interrupt rate of one DMA channel. Instead of raising an interrupt for every finished packet, it counts packet completions against a programmable threshold. It also runs an idle timer that gives a late interrupt when packets stop arriving before the threshold is reached. The idle timer is armed only while at least one completed packet has not yet been reported. A separate error pulse sets its own sticky status bit.

Software works through a small word-wide register port with combinational read data. The control word holds the source enables, the packet threshold and the idle delay. Two further addresses set or clear enable bits by mask. The status word holds the sticky event bits, and writing ones to it clears them. The interrupt output is a level: it stays high while any enabled status bit is set.

Top module: `irq_coalesce`

## Requirements
- R1: Bit 0 of status (count event) sets in the cycle after the packet-done pulse that brings the count since the last reload up to the threshold. A threshold of 0 behaves as 1.
- R2: With delay D not 0 and a packet pending, bit 1 of status (idle event) sets in the cycle after the D-th tick pulse that follows the most recent packet-done pulse.
- R3: The idle event never fires while no packet is pending. A delay of 0 turns the idle event off.
- R4: After reset, the control word at address 0 reads 0x0000_0100: enables in bits [2:0] are 0, the threshold in bits [15:8] is 1, and the delay in bits [31:16] is 0. Status at address 3 reads 0 and irq_o is low.
- R5: Writing a mask to address 1 sets those enable bits, and writing a mask to address 2 clears them. Other enable bits keep their value. Addresses 1 and 2 read back the enables in bits [2:0]. Enable bit 0 is count, bit 1 is idle and bit 2 is error.
- R6: Writing ones to address 3 clears only those status bits. An event in the same cycle keeps its bit set.
- R7: Each packet-done pulse restarts the idle timer, including one that coincides with a tick. The timer advances only on tick pulses.
- R8: When either the count event or the idle event fires, the packet count reloads to the threshold and the pending flag clears.
- R9: An error pulse sets status bit 2 (error event).
- R10: irq_o is high exactly while some status bit and its enable bit are both set.
- R11: Writing the control word reloads the packet count from the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| err_i | input | 1 | One-cycle error pulse |
| tick_i | input | 1 | Time base pulse for the idle timer |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| irq_o | output | 1 | Level interrupt |

## Verification
Packet bursts shorter than, equal to and longer than the threshold separate the count event from the idle event. Packets placed inside a tick stream, including one that lands on the same cycle as a tick, show whether the timer restarts and whether ticks with nothing pending stay silent. Threshold 0, delay 0 and a control write in the middle of a burst probe the reload paths. An acknowledge that coincides with a new event, and enable masks applied while status is set, show that clear priority and the interrupt gating are kept apart.

// File: rtl/icu_pkg.sv
package icu_pkg;
  parameter int THR_W = 8;
  parameter int DLY_W = 16;
  parameter int NSRC  = 3;
  parameter int DW    = 32;
  localparam int THR_LSB = 8;
  localparam int DLY_LSB = THR_LSB + THR_W;
  localparam int SRC_CNT = 0;
  localparam int SRC_DLY = 1;
  localparam int SRC_ERR = 2;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_EN_SET = 2'd1,
    A_EN_CLR = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/icu_pkt_count.sv
module icu_pkt_count
  import icu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_i,
  input  logic             load_i,
  input  logic [THR_W-1:0] load_val_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             dly_fire_i,
  output logic             cnt_fire_o,
  output logic             pending_o
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W-1:0] thr_eff, load_eff;

  assign thr_eff  = (thr_i == '0) ? THR_W'(1) : thr_i;
  assign load_eff = (load_val_i == '0) ? THR_W'(1) : load_val_i;
  assign cnt_fire_o = pkt_i && (cnt_q <= THR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= THR_W'(1);
      pending_o <= 1'b0;
    end else begin
      if (load_i)                       cnt_q <= load_eff;
      else if (cnt_fire_o || dly_fire_i) cnt_q <= thr_eff;
      else if (pkt_i)                   cnt_q <= cnt_q - THR_W'(1);

      if (cnt_fire_o || dly_fire_i) pending_o <= 1'b0;
      else if (pkt_i)               pending_o <= 1'b1;
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0) else $error("count reached zero"); // R1
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_fire_o || dly_fire_i) |=> !pending_o) else $error("pending kept"); // R8
  AST_DLY_NEEDS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_fire_i |-> pending_o) else $error("idle fire without packet"); // R3
endmodule

// File: rtl/icu_delay_timer.sv
module icu_delay_timer
  import icu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_i,
  input  logic             tick_i,
  input  logic             pending_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] tmr_q;
  logic [DLY_W:0]   tmr_inc;
  logic             armed;

  assign tmr_inc = {1'b0, tmr_q} + 1'b1;
  assign armed   = pending_i && (delay_i != '0) && !pkt_i;
  assign fire_o  = armed && tick_i && (tmr_inc >= {1'b0, delay_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (pkt_i || fire_o)   tmr_q <= '0;
    else if (armed && tick_i)   tmr_q <= tmr_inc[DLY_W-1:0];
  end

  AST_TMR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_i |=> (tmr_q == '0)) else $error("timer not restarted"); // R7
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !pkt_i) |=> $stable(tmr_q)) else $error("timer moved without tick"); // R7
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NSRC-1:0]  set_i,
  output logic [NSRC-1:0]  en_o,
  output logic [THR_W-1:0] thr_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [NSRC-1:0]  st_o,
  output logic [DW-1:0]    rdata_o
);
  reg_addr_e addr;
  logic [NSRC-1:0] wmask, clr;

  assign addr  = reg_addr_e'(addr_i);
  assign wmask = wdata_i[NSRC-1:0];
  assign clr   = (we_i && addr == A_STAT) ? wmask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      thr_o <= THR_W'(1);
      dly_o <= '0;
    end else if (we_i) begin
      unique case (addr)
        A_CTRL: begin
          en_o  <= wmask;
          thr_o <= wdata_i[THR_LSB +: THR_W];
          dly_o <= wdata_i[DLY_LSB +: DLY_W];
        end
        A_EN_SET: en_o <= en_o | wmask;
        A_EN_CLR: en_o <= en_o & ~wmask;
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= '0;
    else         st_o <= (st_o & ~clr) | set_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_CTRL: begin
        rdata_o[NSRC-1:0]             = en_o;
        rdata_o[THR_LSB +: THR_W]     = thr_o;
        rdata_o[DLY_LSB +: DLY_W]     = dly_o;
      end
      A_EN_SET, A_EN_CLR: rdata_o[NSRC-1:0] = en_o;
      default:            rdata_o[NSRC-1:0] = st_o;
    endcase
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_ack
    AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !set_i[i]) |=> !st_o[i]) else $error("ack failed"); // R6
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_o[i]) else $error("event lost"); // R9
  end

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr == A_EN_SET) |=> ((en_o & $past(wmask)) == $past(wmask)))
    else $error("enable set failed"); // R5
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr == A_EN_CLR) |=> ((en_o & $past(wmask)) == '0))
    else $error("enable clear failed"); // R5
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import icu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pkt_done_i,
  input  logic          err_i,
  input  logic          tick_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [NSRC-1:0]  en, st, set;
  logic [THR_W-1:0] thr;
  logic [DLY_W-1:0] dly;
  logic             cnt_fire, dly_fire, pending, load;

  assign load = reg_we_i && (reg_addr_i == A_CTRL);

  always_comb begin
    set          = '0;
    set[SRC_CNT] = cnt_fire;
    set[SRC_DLY] = dly_fire;
    set[SRC_ERR] = err_i;
  end

  icu_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_i(set), .en_o(en), .thr_o(thr), .dly_o(dly),
    .st_o(st), .rdata_o(reg_rdata_o)
  );

  icu_pkt_count u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_i(pkt_done_i), .load_i(load),
    .load_val_i(reg_wdata_i[THR_LSB +: THR_W]), .thr_i(thr),
    .dly_fire_i(dly_fire), .cnt_fire_o(cnt_fire), .pending_o(pending)
  );

  icu_delay_timer u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_i(pkt_done_i), .tick_i(tick_i),
    .pending_i(pending), .delay_i(dly), .fire_o(dly_fire)
  );

  assign irq_o = |(st & en);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o) else $error("irq while all disabled"); // R10
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnt_fire && dly_fire)) else $error("both events at once"); // R7
endmodule

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pkt = 1'b0, err = 1'b0, tick = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_coalesce u0 (
    .clk_i(clk), .rst_ni(rst_n), .pkt_done_i(pkt), .err_i(err), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  int m_en, m_thr, m_dly, m_cnt, m_tmr, m_st;
  bit m_pend;

  function automatic int eff(int t);
    return (t == 0) ? 1 : t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_thr = 1; m_dly = 0; m_cnt = 1; m_tmr = 0; m_st = 0; m_pend = 0;
    end else begin
      bit fc, fd;
      fc = pkt && (m_cnt <= 1);
      fd = !pkt && tick && m_pend && (m_dly != 0) && (m_tmr + 1 >= m_dly);
      if (we && addr == 2'd3) m_st = m_st & ~int'(wdata[2:0]);
      m_st = m_st | (fc ? 1 : 0) | (fd ? 2 : 0) | (err ? 4 : 0);
      if (we && addr == 2'd0) m_cnt = eff(int'(wdata[15:8]));
      else if (fc || fd)      m_cnt = eff(m_thr);
      else if (pkt)           m_cnt = m_cnt - 1;
      if (fc || fd) m_pend = 0; else if (pkt) m_pend = 1;
      if (pkt || fd) m_tmr = 0;
      else if (tick && m_pend && m_dly != 0) m_tmr = m_tmr + 1;
      if (we) begin
        case (addr)
          2'd0: begin m_en = int'(wdata[2:0]); m_thr = int'(wdata[15:8]); m_dly = int'(wdata[31:16]); end
          2'd1: m_en = m_en | int'(wdata[2:0]);
          2'd2: m_en = m_en & ~int'(wdata[2:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      check("R10 irq", 32'(irq), 32'((m_st & m_en) != 0));
      if (addr == 2'd3) begin
        check("R1 cnt bit", 32'(rdata[0]), 32'(m_st & 1));
        check("R2 idle bit", 32'(rdata[1]), 32'((m_st >> 1) & 1));
        check("R9 err bit", 32'(rdata[2]), 32'((m_st >> 2) & 1));
      end
    end
  end

  task automatic cyc(bit p, bit t, bit e);
    @(negedge clk);
    pkt = p; tick = t; err = e; we = 0; addr = 2'd3; wdata = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    pkt = 0; tick = 0; err = 0; we = 1; addr = a; wdata = d;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    pkt = 0; tick = 0; err = 0; we = 0; addr = a; wdata = '0;
    #3 check(tag, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, 32'h0000_0100, "R4 ctrl reset");
    rd(2'd3, 32'h0, "R4 status reset");
    check("R4 irq reset", 32'(irq), 32'h0);
    // R5 mask set/clear
    wr(2'd1, 32'h3); rd(2'd1, 32'h3, "R5 set");
    wr(2'd2, 32'h1); rd(2'd2, 32'h2, "R5 clear");
    wr(2'd1, 32'h4); rd(2'd1, 32'h6, "R5 set keeps");
    rd(2'd0, 32'h0000_0106, "R5 ctrl view");
    // R1 threshold 3, delay 5
    wr(2'd0, 32'h0005_0307);
    cyc(1,0,0); cyc(0,0,0); cyc(1,0,0); cyc(1,0,0); cyc(0,0,0);
    rd(2'd3, 32'h1, "R1 threshold");
    check("R10 irq on count", 32'(irq), 32'h1);
    wr(2'd3, 32'h1); rd(2'd3, 32'h0, "R6 ack");
    // R2 idle timeout
    cyc(1,0,0); cyc(1,0,0);
    for (int i = 0; i < 4; i++) cyc(0,1,0);
    rd(2'd3, 32'h0, "R2 before timeout");
    cyc(0,1,0);
    rd(2'd3, 32'h2, "R2 timeout");
    wr(2'd3, 32'h2);
    // R8 reload after idle event
    cyc(1,0,0); cyc(1,0,0);
    rd(2'd3, 32'h0, "R8 reloaded");
    cyc(1,0,0);
    rd(2'd3, 32'h1, "R8 full threshold");
    wr(2'd3, 32'h1);
    // R3 no pending packet
    for (int i = 0; i < 10; i++) cyc(0,1,0);
    rd(2'd3, 32'h0, "R3 idle without packet");
    // R7 restart, packet on a tick
    cyc(1,0,0);
    for (int i = 0; i < 3; i++) cyc(0,1,0);
    cyc(1,1,0);
    for (int i = 0; i < 4; i++) cyc(0,1,0);
    rd(2'd3, 32'h0, "R7 restarted");
    cyc(0,1,0);
    rd(2'd3, 32'h2, "R7 timeout after restart");
    wr(2'd3, 32'h2);
    // R9 and R10 gating
    cyc(0,0,1);
    rd(2'd3, 32'h4, "R9 error sticky");
    check("R10 irq on error", 32'(irq), 32'h1);
    wr(2'd2, 32'h4);
    rd(2'd3, 32'h4, "R10 status kept");
    check("R10 irq masked", 32'(irq), 32'h0);
    wr(2'd3, 32'h4);
    // R6 event wins over ack
    cyc(1,0,0); cyc(1,0,0);
    @(negedge clk);
    pkt = 1; tick = 0; err = 0; we = 1; addr = 2'd3; wdata = 32'h1;
    rd(2'd3, 32'h1, "R6 set wins");
    wr(2'd3, 32'h1);
    // R1 threshold zero acts as one
    wr(2'd0, 32'h0005_0003);
    cyc(1,0,0);
    rd(2'd3, 32'h1, "R1 threshold zero");
    wr(2'd3, 32'h1);
    // R3 delay zero
    wr(2'd0, 32'h0000_0203);
    cyc(1,0,0);
    for (int i = 0; i < 20; i++) cyc(0,1,0);
    rd(2'd3, 32'h0, "R3 delay zero");
    // R11 control write reloads count
    wr(2'd0, 32'h0000_0203);
    cyc(1,0,0);
    rd(2'd3, 32'h0, "R11 reloaded");
    cyc(1,0,0);
    rd(2'd3, 32'h1, "R11 fires at new threshold");
    cyc(0,0,0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule